// File: doc/BRIEF.md
# Embedded-Clock Word Framer

This block rebuilds 12-bit serial frames from a link that sends one start bit, ten payload bits and one stop bit per word. A fixed 1:6 deserializer in front of it delivers six serial bits per accepted group. Two groups make one frame, but the frame boundary can sit at any of twelve bit positions relative to the group pairs.

During synchronization the transmitter sends all-ones payloads. The stop bit is then the only zero on the line. The framer keeps a short history of recent bits and looks for a window of eleven ones followed by a zero. Once the same bit position has matched on several frames in a row, it locks. It then holds that boundary, because the link is frequency-locked and does not drift. While locked it emits one 10-bit word with a single-cycle strobe per frame. It flags every frame whose start or stop bit is wrong, and gives up lock after a run of bad frames.

Top module: `ecw_framer`

## Requirements
- R1: A group is taken only in a cycle where `grp_vld_i` is 1. Bit 5 of `grp_i` is the earliest bit on the line and bit 0 the latest. Cycles with `grp_vld_i` at 0 have no effect, whatever `grp_i` carries.
- R2: On the line, a frame is the start bit (1), then payload bits 9 down to 0, then the stop bit (0). `word_o` presents the payload with bit 9 as the first payload bit received.
- R3: A sync frame is a start bit, ten payload ones and a zero stop bit. The boundary is found at any of the 12 bit offsets.
- R4: `locked_o` rises only after sync frames have matched at one offset on 4 consecutive frame evaluations. Three sync frames after reset never give lock. No word strobe is given in the cycle lock is declared.
- R5: While locked, `word_vld_o` pulses for exactly one cycle per frame, i.e. after every second accepted group. It is never high in two consecutive cycles, and never high unless lock was held in the cycle before.
- R6: While locked, a frame whose start bit is 0 or whose stop bit is 1 raises `err_o` together with its word strobe. A correct frame leaves `err_o` low. Lock is held through fewer than 8 consecutive bad frames.
- R7: The 8th consecutive bad frame drops lock. A later run of sync frames locks again.
- R8: A synchronous active-high `rst` clears lock, the error run count and all outputs to 0 by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_i | input | 6 | Deserialized bit group, bit 5 earliest |
| grp_vld_i | input | 1 | Group present this cycle |
| word_o | output | 10 | Recovered payload word |
| word_vld_o | output | 1 | One-cycle word strobe |
| err_o | output | 1 | Framing error on the strobed word |
| locked_o | output | 1 | Boundary held |

## Verification
The framer is driven with sync runs preceded by 0, 5, 11 and two random numbers of lead bits. This shows that every offset class is found, and that three frames are too few for lock. Random non-all-ones payloads then confirm word order and bit order. Random idle cycles with garbage on `grp_i` separate accepted groups from ignored ones. Bad start bits and bad stop bits, in runs of three and of eight, tell error reporting apart from lock loss, and a later sync run shows relock.

// File: rtl/ecw_pkg.sv
package ecw_pkg;
  typedef enum logic {ST_SEEK = 1'b0, ST_LOCK = 1'b1} lock_st_t;
endpackage

// File: rtl/ecw_history.sv
module ecw_history #(
  parameter int GRP_W  = 6,
  parameter int FRM_W  = 12,
  parameter int HIST_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic              grp_vld_i,
  output logic [HIST_W-1:0] hist_n_o,
  output logic              eval_o
);
  localparam int GPF = FRM_W / GRP_W;
  localparam int PH_W = (GPF > 1) ? $clog2(GPF) : 1;

  logic [HIST_W-1:0] hist;
  logic [PH_W-1:0]   ph;

  assign hist_n_o = {hist[HIST_W-GRP_W-1:0], grp_i};
  assign eval_o   = grp_vld_i && (ph == PH_W'(GPF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      ph   <= '0;
    end else if (grp_vld_i) begin
      hist <= hist_n_o;
      ph   <= (ph == PH_W'(GPF - 1)) ? '0 : ph + 1'b1;
    end
  end
endmodule

// File: rtl/ecw_seek.sv
module ecw_seek #(
  parameter int FRM_W  = 12,
  parameter int HIST_W = 24,
  parameter int OFF_W  = 4
) (
  input  logic [HIST_W-1:0] hist_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam logic [FRM_W-1:0] SYNC_PAT = {{(FRM_W-1){1'b1}}, 1'b0};

  logic [FRM_W-1:0] hit;

  genvar k;
  generate
    for (k = 0; k < FRM_W; k++) begin : g_off
      assign hit[k] = (hist_i[k+FRM_W-1:k] == SYNC_PAT);
    end
  endgenerate

  always_comb begin
    off_o = '0;
    for (int j = FRM_W - 1; j >= 0; j--) begin
      if (hit[j]) off_o = OFF_W'(j);
    end
  end

  assign hit_o = |hit;
endmodule

// File: rtl/ecw_lock.sv
module ecw_lock
  import ecw_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int FRM_W  = 12,
  parameter int HIST_W = 24,
  parameter int OFF_W  = 4,
  parameter int LOCK_N = 4,
  parameter int DROP_N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_i,
  input  logic [HIST_W-1:0] hist_i,
  input  logic              hit_i,
  input  logic [OFF_W-1:0]  hit_off_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              err_o,
  output logic              locked_o
);
  localparam int CNT_W = $clog2(LOCK_N + 1);
  localparam int ERR_W = $clog2(DROP_N + 1);

  lock_st_t          st;
  logic [OFF_W-1:0]  off, cand;
  logic [CNT_W-1:0]  cnt;
  logic [ERR_W-1:0]  errc;
  logic [HIST_W-1:0] shifted;
  logic [FRM_W-1:0]  frm;
  logic              bad;

  assign shifted = hist_i >> off;
  assign frm     = shifted[FRM_W-1:0];
  assign bad     = !frm[FRM_W-1] || frm[0];
  assign locked_o = (st == ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_SEEK; off <= '0; cand <= '0; cnt <= '0; errc <= '0;
      word_o <= '0; word_vld_o <= 1'b0; err_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      err_o      <= 1'b0;
      if (eval_i) begin
        if (st == ST_SEEK) begin
          if (hit_i && cnt != '0 && hit_off_i == cand) begin
            if (cnt == CNT_W'(LOCK_N - 1)) begin
              st   <= ST_LOCK;
              off  <= cand;
              cnt  <= '0;
              errc <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (hit_i) begin
            cand <= hit_off_i;
            cnt  <= CNT_W'(1);
          end else begin
            cnt <= '0;
          end
        end else begin
          word_o     <= frm[FRM_W-2:1];
          word_vld_o <= 1'b1;
          err_o      <= bad;
          if (!bad) begin
            errc <= '0;
          end else if (errc == ERR_W'(DROP_N - 1)) begin
            st   <= ST_SEEK;
            errc <= '0;
            cnt  <= '0;
          end else begin
            errc <= errc + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ecw_framer.sv
module ecw_framer #(
  parameter int GRP_W  = 6,
  parameter int DATA_W = 10,
  parameter int LOCK_N = 4,
  parameter int DROP_N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic              grp_vld_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              err_o,
  output logic              locked_o
);
  localparam int FRM_W  = DATA_W + 2;
  localparam int HIST_W = 2 * FRM_W;
  localparam int OFF_W  = $clog2(FRM_W);

  logic [HIST_W-1:0] hist_n;
  logic              eval, hit;
  logic [OFF_W-1:0]  hit_off;

  ecw_history #(.GRP_W(GRP_W), .FRM_W(FRM_W), .HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .grp_i(grp_i), .grp_vld_i(grp_vld_i),
    .hist_n_o(hist_n), .eval_o(eval)
  );

  ecw_seek #(.FRM_W(FRM_W), .HIST_W(HIST_W), .OFF_W(OFF_W)) u_seek (
    .hist_i(hist_n), .hit_o(hit), .off_o(hit_off)
  );

  ecw_lock #(.DATA_W(DATA_W), .FRM_W(FRM_W), .HIST_W(HIST_W), .OFF_W(OFF_W),
             .LOCK_N(LOCK_N), .DROP_N(DROP_N)) u_lock (
    .clk(clk), .rst(rst), .eval_i(eval), .hist_i(hist_n), .hit_i(hit),
    .hit_off_i(hit_off), .word_o(word_o), .word_vld_o(word_vld_o),
    .err_o(err_o), .locked_o(locked_o)
  );
endmodule

// File: rtl/ecw_framer_chk.sv
module ecw_framer_chk (
  input logic clk,
  input logic rst,
  input logic word_vld_o,
  input logic err_o,
  input logic locked_o
);
  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);
  // R5
  strobe_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> $past(locked_o));
  // R6
  err_with_word_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> word_vld_o);
  // R4
  lock_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> !word_vld_o);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!locked_o && !word_vld_o && !err_o));
endmodule

bind ecw_framer ecw_framer_chk u_chk (
  .clk(clk), .rst(rst), .word_vld_o(word_vld_o), .err_o(err_o),
  .locked_o(locked_o)
);

// File: tb/tb_ecw_framer.sv
module tb_ecw_framer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] grp_i = '0;
  logic       grp_vld_i = 1'b0;
  logic [9:0] word_o;
  logic       word_vld_o, err_o, locked_o;

  int checks = 0;
  int errors = 0;
  bit q[$];
  logic [9:0] got_w[$];
  int err_seen = 0;
  logic [9:0] exp_w[$];

  always #2 clk = ~clk;

  ecw_framer dut (.clk(clk), .rst(rst), .grp_i(grp_i), .grp_vld_i(grp_vld_i),
    .word_o(word_o), .word_vld_o(word_vld_o), .err_o(err_o), .locked_o(locked_o));

  always @(negedge clk) begin
    if (!rst && word_vld_o) begin
      got_w.push_back(word_o);
      if (err_o) err_seen++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] make_frame(input logic [9:0] pl, input bit st, input bit sp);
    return {st, pl, sp};
  endfunction

  task automatic push_frame(input logic [9:0] pl, input bit st, input bit sp);
    logic [11:0] f = make_frame(pl, st, sp);
    for (int i = 11; i >= 0; i--) q.push_back(f[i]);
  endtask

  task automatic push_sync(input int n);
    for (int i = 0; i < n; i++) push_frame(10'h3FF, 1'b1, 1'b0);
  endtask

  task automatic feed();
    while (q.size() >= 6) begin
      @(negedge clk);
      if ($urandom % 4 == 0) begin
        grp_vld_i = 1'b0;
        grp_i = 6'($urandom);
      end else begin
        for (int i = 5; i >= 0; i--) grp_i[i] = q.pop_front();
        grp_vld_i = 1'b1;
      end
    end
    @(negedge clk);
    grp_vld_i = 1'b0;
    grp_i = 6'($urandom);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    grp_vld_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q.delete();
  endtask

  task automatic scenario(input int lead);
    int first;
    logic [9:0] pl;
    do_reset();
    check("R8 reset locked", locked_o, 0);
    check("R8 reset strobe", word_vld_o, 0);
    for (int i = 0; i < lead; i++) q.push_back(1'b1);
    push_sync(3);
    feed();
    check("R4 no lock after 3 sync frames", locked_o, 0);
    push_sync(5);
    feed();
    check("R3 lock found at lead offset", locked_o, 1);
    // R2 payload order
    got_w.delete(); exp_w.delete();
    for (int i = 0; i < 6; i++) begin
      pl = 10'($urandom);
      if (pl == 10'h3FF) pl = 10'h155;
      exp_w.push_back(pl);
      push_frame(pl, 1'b1, 1'b0);
    end
    push_sync(2);
    err_seen = 0;
    feed();
    first = -1;
    for (int i = 0; i < got_w.size(); i++)
      if (first < 0 && got_w[i] != 10'h3FF) first = i;
    check("R2 data words present", (first >= 0 && first + 6 <= got_w.size()), 1);
    if (first >= 0 && first + 6 <= got_w.size())
      for (int i = 0; i < 6; i++) check("R2 word value", got_w[first+i], exp_w[i]);
    check("R6 no error on good frames", err_seen, 0);
    // R6 short bad run keeps lock
    err_seen = 0;
    push_frame(10'h0F0, 1'b1, 1'b1);
    push_frame(10'h0F0, 1'b0, 1'b0);
    push_frame(10'h3FF, 1'b1, 1'b1);
    push_frame(10'h123, 1'b1, 1'b0);
    push_frame(10'h124, 1'b1, 1'b0);
    feed();
    check("R6 three errors flagged", err_seen, 3);
    check("R6 lock held", locked_o, 1);
    // R7 long bad run drops lock
    err_seen = 0;
    for (int i = 0; i < 8; i++) push_frame(10'h2A5, i[0], i[0]);
    push_frame(10'h123, 1'b1, 1'b0);
    push_frame(10'h124, 1'b1, 1'b0);
    feed();
    check("R7 eight errors flagged", err_seen, 8);
    check("R7 lock dropped", locked_o, 0);
    push_sync(8);
    feed();
    check("R7 relock on sync", locked_o, 1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (2) @(negedge clk);
    check("R8 initial locked", locked_o, 0);
    scenario(0);
    scenario(5);
    scenario(11);
    scenario($urandom % 12);
    scenario($urandom % 12);
    // R8 reset while locked
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 reset clears lock", locked_o, 0);
    check("R8 reset clears err", err_o, 0);
    // R1 idle garbage ignored: zero-heavy junk with grp_vld_i low
    q.delete();
    push_sync(8);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); grp_vld_i = 1'b0; grp_i = 6'h00;
    end
    feed();
    check("R1 idle groups ignored, lock reached", locked_o, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule